// File: doc/BRIEF.md
# Periodic Down-Counting Timer with Register Interface

This block is a 32-bit countdown timer for a simple word-addressed register bus. Software loads a reload value, then starts or stops the count with one-shot command bits in the control word. The live count can be read back at any time. The count moves only on cycles where a single tick-enable input is high, so the tick rate (nominally 50 MHz) is set by whatever logic drives that enable.

When the count runs out, a sticky timeout flag is set. In auto-reload mode the counter refills from the stored reload value and keeps running. Otherwise it stops at zero. A level interrupt is raised while the timeout flag and the interrupt-enable bit are both set. Software acknowledges the timeout by writing anything to the status word.

Top module: `ctmr_top`

## Requirements
- R1: There are four word registers at word addresses 0 (status), 1 (control), 2 (reload value) and 3 (live count). A read of any word address from 4 upward returns zero, and a write to such an address changes no register.
- R2: An access counts only when all four byte enables are set (`bus_be` = 4'hF). Any other access writes nothing and reads back zero.
- R3: `irq_o` is high exactly when status bit 0 (timeout) and control bit 0 (interrupt enable) are both set, with no added cycle of delay.
- R4: A write to the status word clears the timeout bit whatever the data. If an expiry happens in the same cycle, the timeout bit stays set.
- R5: A control write stores the whole word, which reads back as written. Bit 2 set starts the counter and bit 3 set stops it. When both are set, stop wins. Status bit 1 reads 1 while the counter runs.
- R6: A write to the reload word stores the value and puts it into the live count from the next cycle on. A tick in that same cycle is dropped.
- R7: On a cycle with the counter running, the tick enable high and a count above 1, the count drops by one. When the tick enable is low or the counter is stopped, the count holds.
- R8: Expiry happens on a running tick with a count of 1 or 0. It sets the timeout bit. If control bit 1 (auto-reload) is set, the count refills from the reload word and keeps running. If it is clear, the count becomes 0 and the counter stops.
- R9: Reading the live-count word returns the current count, and writes to that word are ignored.
- R10: After reset every register and the count are zero, the counter is stopped and `irq_o` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tick_en | input | 1 | Count-enable strobe that sets the tick rate |
| bus_sel | input | 1 | Access valid this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Word address |
| bus_be | input | 4 | Byte enables; only 4'hF is accepted |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid during a read access |
| irq_o | output | 1 | Level interrupt |

## Verification
The embedded assertions check the following on every cycle:
- a stop command always leaves the counter halted;
- a reload write always lands in the count;
- an idle or stopped counter holds its value;
- a one-shot expiry halts at zero;
- a status write without a coincident expiry clears the timeout.

The bench scenarios cover what needs a sequence to show:
- the exact number of ticks to expiry;
- refill in auto-reload mode;
- the interrupt following the enable bit and the acknowledge;
- the dropped partial-word, unmapped and live-count writes;
- the case where a status write meets an expiry in the same cycle.

// File: rtl/ctmr_pkg.sv
package ctmr_pkg;
  // word indices of the register file
  localparam int unsigned IDX_STAT = 0;
  localparam int unsigned IDX_CTRL = 1;
  localparam int unsigned IDX_RLD  = 2;
  localparam int unsigned IDX_CNT  = 3;

  // control word bits
  localparam int unsigned CB_IRQEN = 0;
  localparam int unsigned CB_AUTO  = 1;
  localparam int unsigned CB_GO    = 2;
  localparam int unsigned CB_HALT  = 3;

  // status word bits
  localparam int unsigned SB_DONE = 0;
  localparam int unsigned SB_RUN  = 1;

  typedef struct packed {
    logic stat_wr;
    logic ctrl_wr;
    logic rld_wr;
    logic rd_en;
  } bus_strb_t;
endpackage

// File: rtl/ctmr_decode.sv
module ctmr_decode
  import ctmr_pkg::*;
#(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned BE_W   = 4
) (
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BE_W-1:0]   bus_be,
  output bus_strb_t         strb
);
  logic full_word;
  logic wr_acc;

  always_comb begin
    full_word     = (bus_be == {BE_W{1'b1}});
    wr_acc        = bus_sel && bus_we && full_word;
    strb.stat_wr  = wr_acc && (bus_addr == ADDR_W'(IDX_STAT));
    strb.ctrl_wr  = wr_acc && (bus_addr == ADDR_W'(IDX_CTRL));
    strb.rld_wr   = wr_acc && (bus_addr == ADDR_W'(IDX_RLD));
    strb.rd_en    = bus_sel && !bus_we && full_word;
  end
endmodule

// File: rtl/ctmr_counter.sv
module ctmr_counter #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_en,
  input  logic             go_cmd,
  input  logic             halt_cmd,
  input  logic             load_en,
  input  logic [CNT_W-1:0] load_val,
  input  logic             auto_rld,
  input  logic [CNT_W-1:0] rld_val,
  output logic [CNT_W-1:0] count,
  output logic             running,
  output logic             expire
);
  logic [CNT_W-1:0] count_nxt;
  logic             run_nxt;
  logic             step;
  logic             last;

  always_comb begin
    step      = running && tick_en && !load_en;
    last      = (count <= CNT_W'(1));
    expire    = step && last;
    count_nxt = count;
    run_nxt   = running;
    if (load_en) begin
      count_nxt = load_val;
    end else if (step) begin
      if (last) begin
        count_nxt = auto_rld ? rld_val : '0;
        run_nxt   = auto_rld;
      end else begin
        count_nxt = count - CNT_W'(1);
      end
    end
    if (halt_cmd) begin
      run_nxt = 1'b0;
    end else if (go_cmd) begin
      run_nxt = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count   <= '0;
      running <= 1'b0;
    end else begin
      count   <= count_nxt;
      running <= run_nxt;
    end
  end

  AST_HALT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    halt_cmd |=> !running); // R5
  AST_LOAD_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    load_en |=> (count == $past(load_val))); // R6
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    ((!running || !tick_en) && !load_en) |=> $stable(count)); // R7
  AST_ONESHOT_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && !auto_rld && !go_cmd) |=> (!running && count == '0)); // R8
endmodule

// File: rtl/ctmr_regs.sv
module ctmr_regs
  import ctmr_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  bus_strb_t         strb,
  input  logic [DATA_W-1:0] wdata,
  input  logic              expire,
  output logic              done_q,
  output logic [DATA_W-1:0] ctrl_q,
  output logic [DATA_W-1:0] rld_q
);
  logic              done_nxt;
  logic [DATA_W-1:0] ctrl_nxt;
  logic [DATA_W-1:0] rld_nxt;

  always_comb begin
    done_nxt = done_q;
    if (strb.stat_wr) done_nxt = 1'b0;
    if (expire)       done_nxt = 1'b1;
    ctrl_nxt = strb.ctrl_wr ? wdata : ctrl_q;
    rld_nxt  = strb.rld_wr  ? wdata : rld_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q <= 1'b0;
      ctrl_q <= '0;
      rld_q  <= '0;
    end else begin
      done_q <= done_nxt;
      ctrl_q <= ctrl_nxt;
      rld_q  <= rld_nxt;
    end
  end

  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.stat_wr && !expire) |=> !done_q); // R4
  AST_EXPIRY_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> done_q); // R8
endmodule

// File: rtl/ctmr_top.sv
module ctmr_top
  import ctmr_pkg::*;
#(
  parameter int unsigned DATA_W      = 32,
  parameter int unsigned ADDR_W      = 4,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [3:0]        bus_be,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq_o
);
  localparam int unsigned BE_W = DATA_W / 8;

  logic              rst_int_n;
  logic [SYNC_STAGES-1:0] rst_pipe;
  bus_strb_t         strb;
  logic              done_q;
  logic [DATA_W-1:0] ctrl_q;
  logic [DATA_W-1:0] rld_q;
  logic [DATA_W-1:0] count;
  logic              running;
  logic              expire;
  logic [DATA_W-1:0] stat_word;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_int_n = rst_pipe[SYNC_STAGES-1];

  ctmr_decode #(.ADDR_W(ADDR_W), .BE_W(BE_W)) u_decode (
    .bus_sel  (bus_sel),
    .bus_we   (bus_we),
    .bus_addr (bus_addr),
    .bus_be   (bus_be),
    .strb     (strb)
  );

  ctmr_regs #(.DATA_W(DATA_W)) u_regs (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .strb   (strb),
    .wdata  (bus_wdata),
    .expire (expire),
    .done_q (done_q),
    .ctrl_q (ctrl_q),
    .rld_q  (rld_q)
  );

  ctmr_counter #(.CNT_W(DATA_W)) u_counter (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .tick_en  (tick_en),
    .go_cmd   (strb.ctrl_wr && bus_wdata[CB_GO]),
    .halt_cmd (strb.ctrl_wr && bus_wdata[CB_HALT]),
    .load_en  (strb.rld_wr),
    .load_val (bus_wdata),
    .auto_rld (ctrl_q[CB_AUTO]),
    .rld_val  (rld_q),
    .count    (count),
    .running  (running),
    .expire   (expire)
  );

  always_comb begin
    stat_word          = '0;
    stat_word[SB_DONE] = done_q;
    stat_word[SB_RUN]  = running;
    bus_rdata          = '0;
    if (strb.rd_en) begin
      case (bus_addr)
        ADDR_W'(IDX_STAT): bus_rdata = stat_word;
        ADDR_W'(IDX_CTRL): bus_rdata = ctrl_q;
        ADDR_W'(IDX_RLD):  bus_rdata = rld_q;
        ADDR_W'(IDX_CNT):  bus_rdata = count;
        default:           bus_rdata = '0;
      endcase
    end
    irq_o = done_q && ctrl_q[CB_IRQEN];
  end

  AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_int_n)
    irq_o |-> (ctrl_q[CB_IRQEN] && done_q && !$isunknown(ctrl_q))); // R3
endmodule

// File: tb/ctmr_top_tb_top.sv
module ctmr_top_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk;
  logic        rst_n;
  logic        tick_en;
  logic        bus_sel;
  logic        bus_we;
  logic [3:0]  bus_addr;
  logic [3:0]  bus_be;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic        irq_o;

  int n_cmp;
  int n_bad;
  bit done_flag;

  logic [31:0] exp_q[$];
  string       tag_q[$];

  ctmr_top dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_en   (tick_en),
    .bus_sel   (bus_sel),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_be    (bus_be),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .irq_o     (irq_o)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // monitor: pop an expected item for every read seen on the bus
  always @(negedge clk) begin
    if (rst_n && bus_sel && !bus_we) begin
      if (exp_q.size() == 0) begin
        n_cmp++; n_bad++;
        $display("FAIL scoreboard: read with no expected item, got %h", bus_rdata);
      end else begin
        logic [31:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        n_cmp++;
        if (bus_rdata !== e) begin
          n_bad++;
          $display("FAIL %s: addr %0d actual %h expected %h", t, bus_addr, bus_rdata, e);
        end
      end
    end
  end

  task automatic access(input bit we, input logic [3:0] a, input logic [3:0] be,
                        input logic [31:0] d, input bit tk);
    @(posedge clk); #1;
    bus_sel = 1'b1; bus_we = we; bus_addr = a; bus_be = be; bus_wdata = d; tick_en = tk;
    @(posedge clk); #1;
    bus_sel = 1'b0; bus_we = 1'b0; tick_en = 1'b0;
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    access(1'b1, a, 4'hF, d, 1'b0);
  endtask

  task automatic rd(input logic [3:0] a, input logic [31:0] e, input string t);
    exp_q.push_back(e);
    tag_q.push_back(t);
    access(1'b0, a, 4'hF, 32'h0, 1'b0);
  endtask

  task automatic ticks(input int n);
    @(posedge clk); #1;
    tick_en = 1'b1;
    repeat (n) @(posedge clk);
    #1 tick_en = 1'b0;
  endtask

  task automatic chk_irq(input logic e, input string t);
    n_cmp++;
    if (irq_o !== e) begin
      n_bad++;
      $display("FAIL %s: irq actual %b expected %b", t, irq_o, e);
    end
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: run hung, actual timeout expected completion");
    finish_run();
  end

  initial begin
    n_cmp = 0; n_bad = 0; done_flag = 1'b0;
    rst_n = 1'b0; tick_en = 1'b0; bus_sel = 1'b0; bus_we = 1'b0;
    bus_addr = '0; bus_be = '0; bus_wdata = '0;
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1;

    // R10 reset state
    rd(4'd0, 32'h0, "R10 status");
    rd(4'd1, 32'h0, "R10 control");
    rd(4'd2, 32'h0, "R10 reload");
    rd(4'd3, 32'h0, "R10 count");
    chk_irq(1'b0, "R10 irq");

    // R6 reload write lands in count
    wr(4'd2, 32'd5);
    rd(4'd2, 32'd5, "R6 reload stored");
    rd(4'd3, 32'd5, "R6 count loaded");

    // R5 start
    wr(4'd1, 32'h4);
    rd(4'd0, 32'h2, "R5 run flag");

    // R7 decrement and hold
    ticks(3);
    rd(4'd3, 32'd2, "R7 after 3 ticks");
    rd(4'd3, 32'd2, "R7 holds without tick");

    // R8 one-shot expiry
    ticks(2);
    rd(4'd0, 32'h1, "R8 oneshot status");
    rd(4'd3, 32'd0, "R8 oneshot count");

    // R3 interrupt follows enable
    chk_irq(1'b0, "R3 masked");
    wr(4'd1, 32'h1);
    chk_irq(1'b1, "R3 enabled");
    rd(4'd1, 32'h1, "R5 control readback");

    // R4 acknowledge with arbitrary data
    wr(4'd0, 32'hFFFF_FFFF);
    chk_irq(1'b0, "R4 irq after ack");
    rd(4'd0, 32'h0, "R4 status after ack");

    // R8 auto-reload
    wr(4'd2, 32'd3);
    wr(4'd1, 32'h7);
    ticks(3);
    rd(4'd0, 32'h3, "R8 auto status");
    rd(4'd3, 32'd3, "R8 auto refill");
    chk_irq(1'b1, "R3 auto irq");
    ticks(1);
    rd(4'd3, 32'd2, "R7 auto decrement");
    rd(4'd1, 32'h7, "R5 control word kept");

    // R6 reload while running
    wr(4'd2, 32'd10);
    rd(4'd3, 32'd10, "R6 running reload");

    // R9 count word is read-only
    wr(4'd3, 32'h55);
    rd(4'd3, 32'd10, "R9 write ignored");

    // R1 unmapped
    wr(4'd5, 32'h77);
    rd(4'd2, 32'd10, "R1 reload untouched");
    rd(4'd7, 32'h0, "R1 unmapped read");
    rd(4'd1, 32'h7, "R1 control untouched");

    // R2 partial word
    access(1'b1, 4'd2, 4'h3, 32'd9, 1'b0);
    rd(4'd2, 32'd10, "R2 partial write dropped");
    exp_q.push_back(32'h0); tag_q.push_back("R2 partial read zero");
    access(1'b0, 4'd2, 4'h1, 32'h0, 1'b0);

    // R5 stop beats start
    wr(4'd1, 32'hF);
    rd(4'd0, 32'h1, "R5 stop wins");
    ticks(2);
    rd(4'd3, 32'd10, "R7 stopped holds");

    // R4 expiry beats acknowledge in the same cycle
    wr(4'd0, 32'h0);
    wr(4'd2, 32'd1);
    wr(4'd1, 32'h5);
    access(1'b1, 4'd0, 4'hF, 32'h0, 1'b1);
    rd(4'd0, 32'h1, "R4 expiry wins over ack");
    chk_irq(1'b1, "R4 irq kept");

    repeat (3) @(posedge clk);
    #1;
    if (exp_q.size() != 0) begin
      n_cmp++; n_bad++;
      $display("FAIL scoreboard: %0d reads pending, expected 0", exp_q.size());
    end
    finish_run();
  end
endmodule